// File: doc/BRIEF.md
# Multiword Sticky Right Shifter

This block right-shifts a 128-bit floating-point fraction that is held as four 32-bit words, word 0 being the most significant. It is used in the alignment step of an arithmetic datapath. The caller supplies a shift distance and a sticky bit from earlier steps. The block returns the aligned fraction together with a new sticky bit. That sticky bit is the OR of the incoming sticky and of every bit that fell off the low end. The exponent correction is left to the caller.

The shift happens in two layers of logic. The first layer moves whole 32-bit words down and sends every word that leaves the bottom into the sticky. The second layer is a logarithmic shifter for the remaining 0 to 31 bits, and it collects the bits it drops. Any distance at or beyond the count of significant fraction bits, which is a parameter with a default of 115, short-circuits to an all-zero fraction with the sticky set. The result is registered, so it appears one clock after the inputs are sampled. The block has no handshake.

Top module: `sticky_rshift`

## Requirements
- R1: While `rst` is high at a rising edge, `out_mant` becomes all zero and `out_sticky` becomes 0.
- R2: Outputs change only at a rising edge and reflect the inputs sampled at the previous rising edge (one cycle latency).
- R3: For 1 <= `in_amt` < SIG_W (default 115), `out_mant` equals `in_mant` logically shifted right by `in_amt`, where bits [127:96] form word 0 (most significant) and bits [31:0] form word 3.
- R4: For distances of exactly 32, 64 and 96, whole words move down by 1, 2 and 3 places, the vacated upper words become zero, and the sticky is set if any dropped word is non-zero.
- R5: For distances that are not a multiple of 32, the bits that leave the bottom of word 3 during the sub-word shift are ORed into `out_sticky`.
- R6: When `in_sticky` is 1, `out_sticky` is 1 for every shift distance.
- R7: For `in_amt` >= SIG_W (including values up to 255), `out_mant` is zero and `out_sticky` is 1, even when `in_mant` is zero.
- R8: A distance of 0 is outside the normal range. In that case the block passes `in_mant` unchanged and `out_sticky` equals `in_sticky`.
- R9: When no set bit is lost and `in_sticky` is 0, `out_sticky` is 0, and shifting `out_mant` left by the distance restores `in_mant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_mant | input | 128 | Fraction to shift, word 0 in bits [127:96] |
| in_amt | input | 8 | Right-shift distance in bits |
| in_sticky | input | 1 | Sticky bit carried in from earlier steps |
| out_mant | output | 128 | Registered shifted fraction |
| out_sticky | output | 1 | Registered sticky: incoming sticky OR any lost bit |

## Verification
On every cycle the assertions check several rules. Saturation must give a zero fraction with the sticky set. An incoming sticky must always survive. A zero distance must pass the inputs through. A clear sticky must mean that shifting back recovers the input exactly, both in each stage and at the registered output. Reset clearing is checked as well. The exact bit placement of the word moves and sub-word shifts, and the sticky being raised only by genuinely lost bits, can only be shown by the bench. The bench compares random and corner-case fractions against a full-width reference shift and a reduction-OR of the masked-off bits.

// File: rtl/sticky_rshift_pkg.sv
package sticky_rshift_pkg;
  parameter int WORD_W    = 32;
  parameter int NUM_WORDS = 4;
  parameter int AMT_W     = 8;

  localparam int MANT_W = WORD_W * NUM_WORDS;
  localparam int WSEL_W = $clog2(NUM_WORDS);
  localparam int BSEL_W = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MANT_W-1:0] mant_t;
endpackage

// File: rtl/sticky_rshift_words.sv
module sticky_rshift_words
  import sticky_rshift_pkg::*;
(
  input  mant_t             mant_i,
  input  logic [WSEL_W-1:0] nwords_i,
  output mant_t             mant_o,
  output logic              sticky_o
);
  word_t src [NUM_WORDS];
  word_t dst [NUM_WORDS];
  logic [NUM_WORDS-1:0] dropped;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    word_t pick;
    // word g is the g-th from the top of the fraction
    assign src[g] = mant_i[MANT_W-1-g*WORD_W -: WORD_W];

    always_comb begin
      pick = '0;
      for (int j = 0; j <= g; j++) begin
        if (nwords_i == WSEL_W'(j)) pick = src[g-j];
      end
    end

    assign dst[g] = pick;
    assign mant_o[MANT_W-1-g*WORD_W -: WORD_W] = dst[g];

    // a word leaves the bottom when its index plus the move reaches NUM_WORDS
    assign dropped[g] = (|src[g]) &&
      (({1'b0, nwords_i} + (WSEL_W+1)'(g)) >= (WSEL_W+1)'(NUM_WORDS));
  end

  assign sticky_o = |dropped;

  // R9: a word move that loses nothing is reversible
  always_comb begin
    if (!sticky_o) begin
      a_r9_word_move_lossless: assert ((mant_o << {nwords_i, BSEL_W'(0)}) == mant_i);
    end
  end
endmodule

// File: rtl/sticky_rshift_bits.sv
module sticky_rshift_bits
  import sticky_rshift_pkg::*;
(
  input  mant_t             mant_i,
  input  logic [BSEL_W-1:0] nbits_i,
  output mant_t             mant_o,
  output logic              sticky_o
);
  mant_t stg [BSEL_W+1];
  logic [BSEL_W-1:0] lost;

  assign stg[0] = mant_i;

  for (genvar b = 0; b < BSEL_W; b++) begin : g_stage
    localparam int SH = 1 << b;
    assign stg[b+1] = nbits_i[b] ? (stg[b] >> SH) : stg[b];
    assign lost[b]  = nbits_i[b] && (|stg[b][SH-1:0]);
  end

  assign mant_o   = stg[BSEL_W];
  assign sticky_o = |lost;

  // R5: a sub-word shift with a clear sticky dropped only zero bits
  always_comb begin
    if (!sticky_o) begin
      a_r5_bit_shift_lossless: assert ((mant_o << nbits_i) == mant_i);
    end
  end
endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift
  import sticky_rshift_pkg::*;
#(
  parameter int SIG_W = 115
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MANT_W-1:0]  in_mant,
  input  logic [AMT_W-1:0]   in_amt,
  input  logic               in_sticky,
  output logic [MANT_W-1:0]  out_mant,
  output logic               out_sticky
);
  localparam logic [AMT_W-1:0] SAT_AMT = AMT_W'(SIG_W);

  mant_t word_mant, bit_mant;
  logic  word_stk, bit_stk, saturate;

  sticky_rshift_words u_words (
    .mant_i   (in_mant),
    .nwords_i (in_amt[BSEL_W +: WSEL_W]),
    .mant_o   (word_mant),
    .sticky_o (word_stk)
  );

  sticky_rshift_bits u_bits (
    .mant_i   (word_mant),
    .nbits_i  (in_amt[BSEL_W-1:0]),
    .mant_o   (bit_mant),
    .sticky_o (bit_stk)
  );

  assign saturate = (in_amt >= SAT_AMT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_mant   <= '0;
      out_sticky <= 1'b0;
    end else if (saturate) begin
      out_mant   <= '0;
      out_sticky <= 1'b1;
    end else begin
      out_mant   <= bit_mant;
      out_sticky <= in_sticky | word_stk | bit_stk;
    end
  end

  // armed: the previous edge was not a reset edge
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (out_mant == '0 && !out_sticky));

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_amt) >= SAT_AMT) |-> (out_mant == '0 && out_sticky));

  a_r6_sticky_kept: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_sticky)) |-> out_sticky);

  a_r8_zero_passthru: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_amt) == '0) |->
      (out_mant == $past(in_mant) && out_sticky == $past(in_sticky)));

  a_r9_exact_reversible: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_sticky) |-> ((out_mant << $past(in_amt)) == $past(in_mant)));
endmodule

// File: tb/sim_sticky_rshift.sv
`timescale 1ns/1ps
module sim_sticky_rshift;
  localparam int SIG_W = 115;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] in_mant = '0;
  logic [7:0]   in_amt = '0;
  logic         in_sticky = 1'b0;
  logic [127:0] out_mant;
  logic         out_sticky;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sticky_rshift #(.SIG_W(SIG_W)) u0 (
    .clk(clk), .rst(rst), .in_mant(in_mant), .in_amt(in_amt),
    .in_sticky(in_sticky), .out_mant(out_mant), .out_sticky(out_sticky)
  );

  function automatic logic [128:0] ref_shift(input logic [127:0] m,
                                             input logic [7:0] a,
                                             input logic s);
    logic [127:0] om;
    logic os;
    if (a >= 8'(SIG_W)) begin
      om = '0; os = 1'b1;
    end else begin
      om = m >> a;
      os = s | (|(m & ((128'd1 << a) - 128'd1)));
    end
    return {os, om};
  endfunction

  task automatic check(input string tag, input logic [127:0] em, input logic es);
    checks++;
    if (out_mant !== em || out_sticky !== es) begin
      fails++;
      $display("FAIL %s: got mant=%h sticky=%b, expected mant=%h sticky=%b",
               tag, out_mant, out_sticky, em, es);
    end
  endtask

  task automatic apply(input string tag, input logic [127:0] m,
                       input logic [7:0] a, input logic s);
    logic [128:0] e;
    @(negedge clk);
    in_mant = m; in_amt = a; in_sticky = s;
    e = ref_shift(m, a, s);
    @(negedge clk);
    check(tag, e[127:0], e[128]);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: got no finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    logic [128:0] e;
    void'($urandom(32'd2024));
    pat = 128'h89ABCDEF_01234567_FEDCBA98_76543210;

    in_mant = pat; in_amt = 8'd5; in_sticky = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", '0, 1'b0);
    rst = 1'b0;

    apply("R8 zero distance", pat, 8'd0, 1'b0);
    apply("R8 zero distance sticky in", pat, 8'd0, 1'b1);
    apply("R4 move 32", pat, 8'd32, 1'b0);
    apply("R4 move 64", pat, 8'd64, 1'b0);
    apply("R4 move 96", pat, 8'd96, 1'b0);
    apply("R4 move 64 exact", {64'hDEAD_BEEF_0000_0001, 64'd0}, 8'd64, 1'b0);
    apply("R5 shift 1", 128'd1, 8'd1, 1'b0);
    apply("R5 shift 31", pat, 8'd31, 1'b0);
    apply("R5 shift 33", pat, 8'd33, 1'b0);
    apply("R5 shift 97", {32'h8000_0000, 96'd0}, 8'd97, 1'b0);
    apply("R3 shift 114", {1'b1, 127'd0}, 8'd114, 1'b0);
    apply("R3 shift 114 low lost", {1'b1, 126'd0, 1'b1}, 8'd114, 1'b0);
    apply("R7 saturate 115", {1'b1, 127'd0}, 8'd115, 1'b0);
    apply("R7 saturate zero fraction", '0, 8'd200, 1'b0);
    apply("R7 saturate 255", pat, 8'd255, 1'b0);
    apply("R6 sticky in, nothing lost", 128'h100, 8'd8, 1'b1);
    apply("R9 exact, sticky clear", 128'hF000, 8'd12, 1'b0);

    // R2: outputs hold until the next edge
    @(negedge clk);
    in_mant = pat; in_amt = 8'd4; in_sticky = 1'b0;
    e = ref_shift(pat, 8'd4, 1'b0);
    @(negedge clk);
    in_mant = '0; in_amt = 8'd50; in_sticky = 1'b1;
    #1;
    check("R2 hold before edge", e[127:0], e[128]);
    @(negedge clk);
    check("R2 update after edge", '0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [127:0] m;
      m = rnd128();
      if (i % 3 == 0) m = m & ~((128'd1 << ($urandom() % 64)) - 128'd1);
      a = (i % 10 == 0) ? 8'($urandom()) : 8'(($urandom() % 127) + 1);
      apply("R3 random", m, a, 1'($urandom() % 4 == 0));
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", '0, 1'b0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule